// File: doc/BRIEF.md
# Output Compare Channel with Write Protection

This block holds a 16-bit compare value that software loads as two bytes. On each prescaler tick it compares that value with the value of the free-running counter. When they are equal it raises a sticky compare flag and, if its interrupt enable is set, an interrupt request. The counter and its prescaler are outside this block and reach it as the `count` and `tick` inputs.

Writing the upper byte of the compare value suspends all matching until the lower byte is written. Software can therefore change both bytes without a spurious match on a half-updated value. The flag clears by a two-step handshake. First a status read must see the flag set. Then any read or write of the lower compare byte clears it. A match in the same cycle as the clear wins, so no event is lost.

Top module: `oc_channel`

## Requirements
- R1: A write strobe `wr_hi` or `wr_lo` loads `wdata` into the upper or lower compare byte. While `rd_hi` or `rd_lo` is high, `rdata` shows that byte in the same cycle, and the read changes nothing except under the clear rule of R5.
- R2: After a `wr_hi`, no match sets the flag until a `wr_lo` has been taken.
- R3: The flag is set on the clock edge that ends a cycle in which `tick` is high, matching is not suspended, and `count` equals the compare value. A cycle with `tick` low never sets the flag.
- R4: `ctrl_wr` loads bit 6 of `wdata` into the interrupt enable. `irq` is high exactly when the flag and the enable are both 1.
- R5: A `stat_rd` while the flag is 1 arms the clear. The next `rd_lo` or `wr_lo` then clears the flag and disarms. A low-byte access without a prior arming status read leaves the flag unchanged.
- R6: If a clear and a match fall in the same cycle, the flag ends up at 1.
- R7: Reset (`rst_n` low) clears the interrupt enable, the suspension and the arming. It leaves the compare value and the flag unchanged. The compare value and the flag are 0 at time zero.
- R8: While `stat_rd` is high, `rdata` carries the flag in bit 6, and its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler tick; comparisons happen only in cycles where it is high |
| count | input | 16 | Free-running counter value after this tick's update |
| wr_hi | input | 1 | Write strobe for the upper compare byte |
| wr_lo | input | 1 | Write strobe for the lower compare byte |
| rd_hi | input | 1 | Read strobe for the upper compare byte |
| rd_lo | input | 1 | Read strobe for the lower compare byte |
| stat_rd | input | 1 | Status read strobe |
| ctrl_wr | input | 1 | Control write strobe; bit 6 of `wdata` is the interrupt enable |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the strobe that is active |
| flag | output | 1 | Compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that at most one of the bus strobes (`wr_hi`, `wr_lo`, `rd_hi`, `rd_lo`, `stat_rd`, `ctrl_wr`) is high in any cycle, since the read mux and the arm/clear logic give no meaning to overlapping strobes. The stimulus keeps to that rule. Directed phases and a randomized phase each pick a single operation per cycle. `count` is drawn from a small window around the compare value, so matches, suspended matches and clears colliding with matches all occur many times.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int BYTE_W   = 8,
  parameter int EN_BIT   = 6,
  parameter int FLAG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [15:0]       count,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              stat_rd,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              flag,
  output logic              irq
);
  localparam int CMP_W = 2 * BYTE_W;

  logic [CMP_W-1:0]  cmp_q  = '0;
  logic              flag_q = 1'b0;
  logic              inhib_q, arm_q, en_q;
  logic              match, lo_acc, clr;
  logic [BYTE_W-1:0] stat_v;

  assign match  = tick & ~inhib_q & (count == cmp_q);
  assign lo_acc = rd_lo | wr_lo;
  assign clr    = lo_acc & arm_q;

  always_ff @(posedge clk) begin
    if (wr_hi) cmp_q[CMP_W-1:BYTE_W] <= wdata;
    if (wr_lo) cmp_q[BYTE_W-1:0]     <= wdata;
    flag_q <= match | (flag_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inhib_q <= 1'b0;
      arm_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (wr_hi)      inhib_q <= 1'b1;
      else if (wr_lo) inhib_q <= 1'b0;
      if (lo_acc)                  arm_q <= 1'b0;
      else if (stat_rd && flag_q)  arm_q <= 1'b1;
      if (ctrl_wr) en_q <= wdata[EN_BIT];
    end
  end

  always_comb begin
    stat_v = '0;
    stat_v[FLAG_BIT] = flag_q;
  end

  assign rdata = rd_hi   ? cmp_q[CMP_W-1:BYTE_W] :
                 rd_lo   ? cmp_q[BYTE_W-1:0]     :
                 stat_rd ? stat_v                : '0;
  assign flag = flag_q;
  assign irq  = flag_q & en_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo) |=> $stable(cmp_q));

  assert_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inhib_q && !lo_acc) |=> $stable(flag));

  assert_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag) |=> !flag);

  assert_irq_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[EN_BIT]) |=> !irq);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !flag);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && match) |=> flag);

  assert_reset_R7: assert property (@(posedge clk)
    (!rst_n) |=> !irq);
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [15:0] count = 0;
  logic wr_hi = 0, wr_lo = 0, rd_hi = 0, rd_lo = 0, stat_rd = 0, ctrl_wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic flag, irq;

  int checks = 0, errors = 0, cycles = 0;
  int m_cmp = 0;
  bit m_flag = 0, m_arm = 0, m_inh = 0, m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel dut (.clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .rdata(rdata), .flag(flag), .irq(irq));

  // behavioural reference, updated on each edge from the inputs held there
  always @(posedge clk) begin
    bit hit, acc, f_next, arm_next, inh_next, en_next;
    int cmp_next;
    hit = tick && !m_inh && (int'(count) == m_cmp);
    acc = rd_lo || wr_lo;
    f_next = hit ? 1'b1 : ((acc && m_arm) ? 1'b0 : m_flag);
    cmp_next = m_cmp;
    if (wr_hi) cmp_next = (m_cmp % 256) + int'(wdata) * 256;
    if (wr_lo) cmp_next = (m_cmp / 256) * 256 + int'(wdata);
    arm_next = m_arm; inh_next = m_inh; en_next = m_en;
    if (!rst_n) begin
      arm_next = 0; inh_next = 0; en_next = 0;
    end else begin
      if (wr_hi) inh_next = 1; else if (wr_lo) inh_next = 0;
      if (acc) arm_next = 0; else if (stat_rd && m_flag) arm_next = 1;
      if (ctrl_wr) en_next = wdata[6];
    end
    m_flag = f_next; m_cmp = cmp_next; m_arm = arm_next;
    m_inh = inh_next; m_en = en_next;
    cycles++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
    summary();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick = 0; wr_hi = 0; wr_lo = 0; rd_hi = 0; rd_lo = 0; stat_rd = 0; ctrl_wr = 0;
  endtask

  // one clock: edge, then compare flag and irq against the model
  task automatic cyc();
    @(posedge clk); #1;
    chk("R3 R5 R6 flag", int'(flag), int'(m_flag));
    chk("R4 irq", int'(irq), int'(m_flag && m_en));
    @(negedge clk); idle();
  endtask

  task automatic wr(input bit hi, input logic [7:0] d);
    wdata = d; if (hi) wr_hi = 1; else wr_lo = 1; cyc();
  endtask

  task automatic rd(input bit hi, input string req);
    if (hi) rd_hi = 1; else rd_lo = 1; #1;
    chk(req, int'(rdata), hi ? m_cmp / 256 : m_cmp % 256);
    cyc();
  endtask

  task automatic status(input string req);
    stat_rd = 1; #1;
    chk(req, int'(rdata), m_flag ? 8'h40 : 8'h00);
    cyc();
  endtask

  task automatic tk(input logic [15:0] c);
    count = c; tick = 1; cyc();
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
    chk("R7 irq after reset", int'(irq), 0);
    chk("R7 flag at time zero", int'(flag), 0);
    rd(1, "R7 cmp hi at time zero");
    rst_n = 1; @(negedge clk);

    wr(1, 8'h12); wr(0, 8'h34);
    rd(1, "R1 read hi"); rd(0, "R1 read lo");
    chk("R1 value", m_cmp, 16'h1234);
    wdata = 8'h40; ctrl_wr = 1; cyc();

    count = 16'h1234; tick = 0; cyc();
    chk("R3 no tick no set", int'(flag), 0);
    tk(16'h1233);
    chk("R3 mismatch no set", int'(flag), 0);
    tk(16'h1234);
    chk("R3 match sets", int'(flag), 1);
    chk("R4 irq raised", int'(irq), 1);
    status("R8 status shows flag");

    rd(0, "R5 clearing read");
    chk("R5 cleared by read", int'(flag), 0);
    tk(16'h1234);
    rd(0, "R5 unarmed read");
    chk("R5 unarmed access keeps flag", int'(flag), 1);
    status("R8 status armed"); wr(0, 8'h34);
    chk("R5 cleared by write", int'(flag), 0);
    status("R8 status clear");

    wr(1, 8'h55);
    tk(16'h5534);
    chk("R2 inhibited", int'(flag), 0);
    wr(0, 8'h34);
    tk(16'h5534);
    chk("R2 resumes after low write", int'(flag), 1);

    status("R8 arm"); count = 16'h5534; tick = 1; rd_lo = 1; cyc();
    chk("R6 set wins over clear", int'(flag), 1);

    wdata = 8'h00; ctrl_wr = 1; cyc();
    chk("R4 disabled irq", int'(irq), 0);
    wdata = 8'h40; ctrl_wr = 1; cyc();
    rst_n = 0; cyc(); rst_n = 1;
    chk("R7 flag kept over reset", int'(flag), 1);
    chk("R7 enable cleared", int'(irq), 0);
    rd(1, "R7 cmp hi kept"); rd(0, "R7 cmp lo kept");

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      count = 16'h5530 + 16'($urandom_range(0, 7));
      tick = ($urandom_range(0, 3) == 0);
      wdata = (op == 1) ? 8'h55 : 8'($urandom_range(8'h30, 8'h37));
      case (op)
        0: wr_hi = 1;
        1: wr_hi = 1;
        2: wr_lo = 1;
        3: ctrl_wr = 1;
        5: stat_rd = 1;
        6: begin rd_lo = 1; #1; chk("R1 random lo", int'(rdata), m_cmp % 256); end
        7: begin rd_hi = 1; #1; chk("R1 random hi", int'(rdata), m_cmp / 256); end
        default: ;
      endcase
      if (op == 5) begin #1; chk("R8 random status", int'(rdata), m_flag ? 8'h40 : 0); end
      cyc();
    end
    summary();
  end
endmodule